// File: doc/BRIEF.md
# Multi-Target SPI Master

This block is a serial peripheral interface master. It drives the serial clock, a data output and up to four active-low slave selects, and it samples a data input. Software talks to it through a simple register port. A write to the transmit register queues one word. The block asserts the chosen select, waits that target's start delay, and shifts the word out MSB first while it shifts the reply in. It then waits that target's inter-word delay and either sends the next queued word or releases the select.

Each select has its own configuration register. This register sets the clock divider, the clock polarity and phase, the word length and the two delays. Either the mode register or the transmit word picks the target, depending on a mode bit. In the per-word mode, a change of target releases the old select and then applies the new target's timing. A holding register on each side separates software from the shifter. An overrun flag records received words that were dropped.

Top module: `spi_multi_master`

Register map. Write and read use the same address decode.
- 0, mode: [0] per-word select enable, [3:2] fixed target index.
- 1, transmit (write only): [15:0] data, [17:16] target index.
- 2, receive (read only): [15:0] data. Reading it clears the receive-full flag.
- 3, status (read only): [0] transmit empty, [1] receive full, [2] complete, [3] overrun. Reading it clears the overrun flag.
- 4+n, configuration of target n:
  - [7:0] divider (a half period of the serial clock is divider+1 system clocks)
  - [8] polarity
  - [9] phase
  - [13:10] extra bits
  - [23:16] start delay
  - [31:24] inter-word delay

## Requirements
- R1: After reset all selects are high, the serial clock is low, and status reads 0x5 (transmit empty, complete).
- R2: A write to address 1 starts a transfer. The word goes out MSB first, the serial clock makes exactly 2×L transitions, and the received word appears at address 2 with status bit 1 set.
- R3: The serial clock sits at the polarity bit of the active target's configuration whenever no bit is moving. With phase 0, data is sampled on the first edge of each bit. With phase 1, data is sampled on the second edge.
- R4: The word length L is 8 plus the extra-bits field, capped at 16.
- R5: The first serial clock transition comes max(start delay,1) + (divider+1) system clocks after the select falls.
- R6: Words queued for the same target keep its select low, separated by max(inter-word delay,1) clocks. The select rises only after the last queued word and its inter-word delay.
- R7: If a word completes while status bit 1 is still set, the overrun flag (status bit 3) is set and the receive register keeps its old value.
- R8: A status read clears the overrun flag. A receive read clears status bit 1.
- R9: With mode bit 0 clear, the target is mode[3:2], and the index field of the transmit word is ignored.
- R10: With mode bit 0 set, the target is the index in transmit[17:16], mode[3:2] is ignored, and each word uses the timing, polarity and length of its own target.
- R11: At most one select is low at any time. When the target changes, the old select is released before the new one is asserted.
- R12: Status bit 2 is 1 only when the block is idle with no queued word and all selects are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (read side effects) |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from address |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 4 | Active-low slave selects |

## Verification
The assertions assume that software writes the transmit register only while status bit 0 shows it empty. They also assume that every target index written stays below the number of selects, and that read strobes are single-cycle pulses. The bench waits for the transmit-empty flag before each queued write and only uses indices 0 to 3. It loops the serial output back inverted to the serial input, so every received word is a known function of the sent word.

// File: rtl/spim_pkg.sv
package spim_pkg;

   localparam int REG_W  = 32;
   localparam int A_MODE = 0;
   localparam int A_TX   = 1;
   localparam int A_RX   = 2;
   localparam int A_STAT = 3;
   localparam int A_CFG0 = 4;

   typedef struct packed {
      logic [7:0] gap_dly;
      logic [7:0] start_dly;
      logic [1:0] spare;
      logic [3:0] xbits;
      logic       cpha;
      logic       cpol;
      logic [7:0] div;
   } spim_cfg_t;

   typedef enum logic [1:0] {
      SQ_IDLE,
      SQ_LEAD,
      SQ_SHIFT,
      SQ_GAP
   } spim_state_e;

   function automatic logic [7:0] at_least_one(input logic [7:0] v);
      return (v == 8'd0) ? 8'd1 : v;
   endfunction

endpackage

// File: rtl/spim_regs.sv
module spim_regs
   import spim_pkg::*;
#(
   parameter int N_CS   = 4,
   parameter int DATA_W = 16,
   parameter int IDX_W  = 2,
   parameter int ADDR_W = 3
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        wr,
   input  logic                        rd,
   input  logic [ADDR_W-1:0]           addr,
   input  logic [REG_W-1:0]            wdata,
   output logic [REG_W-1:0]            rdata,
   output logic                        sel_var,
   output logic [IDX_W-1:0]            sel_fix,
   output spim_cfg_t [N_CS-1:0]        cfg,
   output logic                        tx_full,
   output logic [DATA_W-1:0]           tx_word,
   output logic [IDX_W-1:0]            tx_idx,
   input  logic                        tx_take,
   input  logic                        rx_push,
   input  logic [DATA_W-1:0]           rx_word,
   output logic                        rx_full,
   output logic                        ovr,
   input  logic                        seq_idle
);

   logic [DATA_W-1:0] rx_q;
   logic              rd_rx, rd_st, wr_tx, wr_mode;

   assign rd_rx   = rd && (addr == ADDR_W'(A_RX));
   assign rd_st   = rd && (addr == ADDR_W'(A_STAT));
   assign wr_tx   = wr && (addr == ADDR_W'(A_TX));
   assign wr_mode = wr && (addr == ADDR_W'(A_MODE));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_var <= 1'b0;
         sel_fix <= '0;
         tx_full <= 1'b0;
         tx_word <= '0;
         tx_idx  <= '0;
         rx_q    <= '0;
         rx_full <= 1'b0;
         ovr     <= 1'b0;
      end else begin
         if (tx_take) tx_full <= 1'b0;
         if (wr_tx) begin
            tx_full <= 1'b1;
            tx_word <= wdata[DATA_W-1:0];
            tx_idx  <= wdata[DATA_W +: IDX_W];
         end
         if (wr_mode) begin
            sel_var <= wdata[0];
            sel_fix <= wdata[2 +: IDX_W];
         end
         if (rd_rx) rx_full <= 1'b0;
         if (rd_st) ovr <= 1'b0;
         if (rx_push) begin
            if (ovr || (rx_full && !rd_rx)) begin
               ovr <= 1'b1;
            end else begin
               rx_q    <= rx_word;
               rx_full <= 1'b1;
            end
         end
      end
   end

   for (genvar g = 0; g < N_CS; g++) begin : g_cfg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            cfg[g] <= '0;
         else if (wr && (addr == ADDR_W'(A_CFG0 + g)))
            cfg[g] <= spim_cfg_t'(wdata);
      end
   end

   always_comb begin
      rdata = '0;
      case (addr)
         ADDR_W'(A_MODE): begin
            rdata[0]           = sel_var;
            rdata[2 +: IDX_W]  = sel_fix;
         end
         ADDR_W'(A_RX):   rdata[DATA_W-1:0] = rx_q;
         ADDR_W'(A_STAT): rdata[3:0] = {ovr, seq_idle && !tx_full, rx_full, !tx_full};
         default: begin
            for (int g = 0; g < N_CS; g++)
               if (addr == ADDR_W'(A_CFG0 + g)) rdata = REG_W'(cfg[g]);
         end
      endcase
   end

endmodule

// File: rtl/spim_seq.sv
module spim_seq
   import spim_pkg::*;
#(
   parameter int N_CS  = 4,
   parameter int IDX_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tx_full,
   input  logic [IDX_W-1:0] tgt,
   input  logic [7:0]       start_dly,
   input  logic [7:0]       gap_dly,
   input  logic             word_done,
   output logic             load,
   output logic             arm,
   output logic [N_CS-1:0]  cs_n,
   output logic [IDX_W-1:0] cur,
   output logic             idle
);

   spim_state_e st;
   logic [7:0]  cnt, lead_lim, gap_lim;
   logic        lead_end, gap_end;

   assign lead_lim = at_least_one(start_dly);
   assign gap_lim  = at_least_one(gap_dly);
   assign lead_end = (st == SQ_LEAD) && (cnt == lead_lim - 8'd1);
   assign gap_end  = (st == SQ_GAP)  && (cnt == gap_lim - 8'd1);
   assign load     = lead_end || (gap_end && tx_full && (tgt == cur));
   assign arm      = (st == SQ_IDLE) && tx_full;
   assign idle     = (st == SQ_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st   <= SQ_IDLE;
         cnt  <= '0;
         cur  <= '0;
         cs_n <= '1;
      end else begin
         case (st)
            SQ_IDLE: if (tx_full) begin
               cur  <= tgt;
               cs_n <= ~(N_CS'(1) << tgt);
               cnt  <= '0;
               st   <= SQ_LEAD;
            end
            SQ_LEAD: begin
               if (lead_end) st <= SQ_SHIFT;
               else          cnt <= cnt + 8'd1;
            end
            SQ_SHIFT: if (word_done) begin
               cnt <= '0;
               st  <= SQ_GAP;
            end
            SQ_GAP: begin
               if (gap_end) begin
                  if (load) begin
                     st <= SQ_SHIFT;
                  end else begin
                     st   <= SQ_IDLE;
                     cs_n <= '1;
                  end
               end else begin
                  cnt <= cnt + 8'd1;
               end
            end
            default: st <= SQ_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/spim_shift.sv
module spim_shift #(
   parameter int DATA_W   = 16,
   parameter int MIN_BITS = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              arm,
   input  logic              arm_cpol,
   input  logic              load,
   input  logic [DATA_W-1:0] tx_word,
   input  logic [7:0]        div,
   input  logic              cpha,
   input  logic [3:0]        xbits,
   input  logic              miso,
   output logic              sck,
   output logic              mosi,
   output logic              done,
   output logic [DATA_W-1:0] rx_word
);

   localparam int LEN_W  = $clog2(DATA_W + 1);
   localparam int ECNT_W = $clog2(2 * DATA_W);

   logic [DATA_W-1:0] tx_sr, rx_sr;
   logic [LEN_W-1:0]  len_new, len_q;
   logic [ECNT_W-1:0] ecnt;
   logic [7:0]        tmr, div_q;
   logic              cpha_q, active, edge_now, sample_now, last_edge;

   always_comb begin
      int ext;
      ext     = MIN_BITS + int'(xbits);
      len_new = (ext > DATA_W) ? LEN_W'(DATA_W) : LEN_W'(ext);
   end

   assign edge_now   = active && (tmr == div_q);
   assign sample_now = (ecnt[0] == cpha_q);
   assign last_edge  = (ecnt == ECNT_W'(2 * int'(len_q) - 1));
   assign mosi       = tx_sr[DATA_W-1];
   assign rx_word    = rx_sr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sck    <= 1'b0;
         tx_sr  <= '0;
         rx_sr  <= '0;
         len_q  <= LEN_W'(MIN_BITS);
         ecnt   <= '0;
         tmr    <= '0;
         div_q  <= '0;
         cpha_q <= 1'b0;
         active <= 1'b0;
         done   <= 1'b0;
      end else begin
         done <= 1'b0;
         if (arm) sck <= arm_cpol;
         if (load) begin
            tx_sr  <= tx_word << (DATA_W - int'(len_new));
            rx_sr  <= '0;
            len_q  <= len_new;
            div_q  <= div;
            cpha_q <= cpha;
            ecnt   <= '0;
            tmr    <= '0;
            active <= 1'b1;
         end else if (edge_now) begin
            tmr  <= '0;
            sck  <= ~sck;
            ecnt <= ecnt + 1'b1;
            if (sample_now)
               rx_sr <= {rx_sr[DATA_W-2:0], miso};
            else if (ecnt != '0)
               tx_sr <= tx_sr << 1;
            if (last_edge) begin
               active <= 1'b0;
               done   <= 1'b1;
            end
         end else if (active) begin
            tmr <= tmr + 8'd1;
         end
      end
   end

endmodule

// File: rtl/spi_multi_master.sv
module spi_multi_master
   import spim_pkg::*;
#(
   parameter int N_CS     = 4,
   parameter int DATA_W   = 16,
   parameter int MIN_BITS = 8,
   localparam int IDX_W   = (N_CS > 1) ? $clog2(N_CS) : 1,
   localparam int ADDR_W  = $clog2(A_CFG0 + N_CS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [REG_W-1:0]  reg_wdata,
   output logic [REG_W-1:0]  reg_rdata,
   output logic              sck,
   output logic              mosi,
   input  logic              miso,
   output logic [N_CS-1:0]   cs_n
);

   if (N_CS < 1 || N_CS > 4) begin : g_bad_ncs
      $error("spi_multi_master: N_CS must be 1..4");
   end
   if (DATA_W < MIN_BITS || DATA_W + IDX_W > REG_W - 14 || MIN_BITS < 2) begin : g_bad_w
      $error("spi_multi_master: DATA_W/MIN_BITS out of range");
   end

   spim_cfg_t [N_CS-1:0] cfg;
   spim_cfg_t            cur_cfg;
   logic                 sel_var, tx_full, rx_full, ovr, seq_idle;
   logic [IDX_W-1:0]     sel_fix, tx_idx, tgt, cur;
   logic [DATA_W-1:0]    tx_word, rx_word;
   logic                 load, arm, done, tgt_cpol;

   spim_regs #(.N_CS(N_CS), .DATA_W(DATA_W), .IDX_W(IDX_W), .ADDR_W(ADDR_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr(reg_wr), .rd(reg_rd), .addr(reg_addr),
      .wdata(reg_wdata), .rdata(reg_rdata), .sel_var(sel_var), .sel_fix(sel_fix),
      .cfg(cfg), .tx_full(tx_full), .tx_word(tx_word), .tx_idx(tx_idx),
      .tx_take(load), .rx_push(done), .rx_word(rx_word), .rx_full(rx_full),
      .ovr(ovr), .seq_idle(seq_idle)
   );

   if (N_CS > 1) begin : g_multi
      assign tgt = sel_var ? tx_idx : sel_fix;
   end else begin : g_single
      assign tgt = '0;
   end

   assign cur_cfg  = cfg[cur];
   assign tgt_cpol = cfg[tgt].cpol;

   spim_seq #(.N_CS(N_CS), .IDX_W(IDX_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .tx_full(tx_full), .tgt(tgt),
      .start_dly(cur_cfg.start_dly), .gap_dly(cur_cfg.gap_dly),
      .word_done(done), .load(load), .arm(arm), .cs_n(cs_n), .cur(cur),
      .idle(seq_idle)
   );

   spim_shift #(.DATA_W(DATA_W), .MIN_BITS(MIN_BITS)) u_shift (
      .clk(clk), .rst_n(rst_n), .arm(arm), .arm_cpol(tgt_cpol), .load(load),
      .tx_word(tx_word), .div(cur_cfg.div), .cpha(cur_cfg.cpha),
      .xbits(cur_cfg.xbits), .miso(miso), .sck(sck), .mosi(mosi),
      .done(done), .rx_word(rx_word)
   );

endmodule

// File: rtl/spim_chk.sv
module spim_chk #(
   parameter int N_CS   = 4,
   parameter int ADDR_W = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic [N_CS-1:0]   cs_n,
   input logic              sck,
   input logic              reg_wr,
   input logic              reg_rd,
   input logic [ADDR_W-1:0] reg_addr,
   input logic              tx_full,
   input logic              rx_full,
   input logic              ovr,
   input logic              seq_idle
);

   // R11: never two selects low together
   p_one_sel_r11: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(~cs_n));

   // R3: clock holds still while no select is low
   p_sck_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (&cs_n && $past(&cs_n)) |-> $stable(sck));

   // R2: a transmit write lands in the holding register
   p_tx_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == ADDR_W'(1)) |=> tx_full);

   // R8: overrun stays until a status read
   p_ovr_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (ovr && !(reg_rd && reg_addr == ADDR_W'(3))) |=> ovr);

   // R7: receive-full holds until the receive register is read
   p_rx_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_full && !(reg_rd && reg_addr == ADDR_W'(2))) |=> rx_full);

   // R6: an idle sequencer drives no select
   p_idle_sel_r6: assert property (@(posedge clk) disable iff (!rst_n)
      seq_idle |-> &cs_n);

endmodule

bind spi_multi_master spim_chk #(.N_CS(N_CS), .ADDR_W(ADDR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .reg_wr(reg_wr),
   .reg_rd(reg_rd), .reg_addr(reg_addr), .tx_full(tx_full),
   .rx_full(rx_full), .ovr(ovr), .seq_idle(seq_idle)
);

// File: tb/test_spi_multi_master.sv
`timescale 1ns/1ps
module test_spi_multi_master;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0, reg_rd = 1'b0;
   logic [2:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        sck, mosi, miso;
   logic [3:0]  cs_n;

   int n_tests = 0, n_fail = 0;
   bit finished = 0;

   always #4 clk = ~clk;
   assign miso = ~mosi;

   spi_multi_master i_spi_multi_master (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .sck(sck), .mosi(mosi), .miso(miso), .cs_n(cs_n)
   );

   // port monitor
   int cyc = 0, t_fall = 0, lead_meas = 0, tog = 0, falls = 0;
   bit lead_pend = 0, multi = 0;
   logic [3:0] prev_cs = 4'hF, last_low = 0, prev_low = 0;
   logic prev_sck = 0;

   always @(negedge clk) begin
      cyc++;
      if (rst_n) begin
         if (&prev_cs && !(&cs_n)) begin
            t_fall = cyc; lead_pend = 1; tog = 0; falls++;
            prev_low = last_low; last_low = ~cs_n;
         end else if (!(&cs_n) && sck != prev_sck) begin
            tog++;
            if (lead_pend) begin lead_meas = cyc - t_fall; lead_pend = 0; end
         end
         if ($countones(~cs_n) > 1) multi = 1;
      end
      prev_cs = cs_n; prev_sck = sck;
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr_reg(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd_reg(input logic [2:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_rd = 1'b1; reg_addr = a;
      #1 d = reg_rdata;
      @(negedge clk);
      reg_rd = 1'b0;
   endtask

   task automatic wait_idle();
      int hi;
      while (&cs_n) @(negedge clk);
      hi = 0;
      while (hi < 3) begin
         @(negedge clk);
         if (&cs_n) hi++; else hi = 0;
      end
   endtask

   task automatic wait_stat(input int bitpos);
      logic [31:0] s;
      s = 0;
      while (s[bitpos] == 1'b0) rd_reg(3'd3, s);
   endtask

   function automatic logic [31:0] mk_cfg(input int dv, input bit pol, input bit ph,
                                          input int xb, input int sd, input int gd);
      return {8'(gd), 8'(sd), 2'b00, 4'(xb), ph, pol, 8'(dv)};
   endfunction

   task automatic t_reset();
      logic [31:0] s;
      chk("R1 selects", 32'(cs_n), 32'hF);
      chk("R1 sck", 32'(sck), 32'h0);
      rd_reg(3'd3, s);
      chk("R1 status", s, 32'h5);
   endtask

   task automatic t_basic();
      logic [31:0] s;
      int f0;
      wr_reg(3'd4, mk_cfg(1, 0, 0, 0, 3, 2));
      wr_reg(3'd0, 32'h0);
      f0 = falls;
      wr_reg(3'd1, 32'h0000_00A5);
      rd_reg(3'd3, s);
      chk("R12 busy not complete", 32'(s[2]), 32'h0);
      wait_idle();
      chk("R2 one select cycle", 32'(falls - f0), 32'h1);
      chk("R9 fixed target 0", 32'(last_low), 32'h1);
      chk("R2 clock transitions", 32'(tog), 32'd16);
      chk("R5 lead time", 32'(lead_meas), 32'd5);
      chk("R3 idle polarity 0", 32'(sck), 32'h0);
      rd_reg(3'd2, s);
      chk("R2 received word", s, 32'h5A);
      rd_reg(3'd3, s);
      chk("R12 complete after read", s, 32'h5);
   endtask

   task automatic t_len();
      logic [31:0] s;
      wr_reg(3'd5, mk_cfg(0, 1, 1, 4, 0, 0));
      wr_reg(3'd0, 32'h4);
      wr_reg(3'd1, 32'h0000_0123);
      wait_idle();
      chk("R4 twelve-bit transitions", 32'(tog), 32'd24);
      chk("R5 zero delay lead", 32'(lead_meas), 32'd2);
      chk("R3 idle polarity 1", 32'(sck), 32'h1);
      chk("R9 fixed target 1", 32'(last_low), 32'h2);
      rd_reg(3'd2, s);
      chk("R3 phase 1 received", s, 32'hEDC);
      wr_reg(3'd6, mk_cfg(2, 0, 1, 15, 1, 1));
      wr_reg(3'd0, 32'h8);
      wr_reg(3'd1, 32'h0000_1234);
      wait_idle();
      chk("R4 capped length", 32'(tog), 32'd32);
      chk("R5 divider lead", 32'(lead_meas), 32'd4);
      rd_reg(3'd2, s);
      chk("R4 sixteen-bit received", s, 32'hEDCB);
   endtask

   task automatic t_back();
      logic [31:0] s;
      int f0;
      wr_reg(3'd4, mk_cfg(1, 0, 0, 0, 2, 5));
      wr_reg(3'd0, 32'h0);
      f0 = falls;
      wr_reg(3'd1, 32'h3C);
      wait_stat(0);
      wr_reg(3'd1, 32'h0F);
      wait_stat(1);
      rd_reg(3'd2, s);
      chk("R6 first queued word", s, 32'hC3);
      wait_idle();
      chk("R6 select held low", 32'(falls - f0), 32'h1);
      chk("R6 transitions both words", 32'(tog), 32'd32);
      rd_reg(3'd2, s);
      chk("R6 second queued word", s, 32'hF0);
   endtask

   task automatic t_ovr();
      logic [31:0] s;
      wr_reg(3'd1, 32'h11);
      wait_stat(0);
      wr_reg(3'd1, 32'h22);
      wait_idle();
      rd_reg(3'd2, s);
      chk("R7 old word kept", s, 32'hEE);
      rd_reg(3'd3, s);
      chk("R7 overrun flagged", s, 32'hD);
      rd_reg(3'd3, s);
      chk("R8 overrun cleared", s, 32'h5);
   endtask

   task automatic t_var();
      logic [31:0] s;
      int f0;
      wr_reg(3'd7, mk_cfg(0, 1, 0, 0, 1, 1));
      wr_reg(3'd0, 32'h1);
      f0 = falls; multi = 0;
      wr_reg(3'd1, (32'd3 << 16) | 32'h81);
      wait_stat(0);
      wr_reg(3'd1, (32'd1 << 16) | 32'h7E);
      wait_idle();
      chk("R11 reselect on change", 32'(falls - f0), 32'h2);
      chk("R10 first target 3", 32'(prev_low), 32'h8);
      chk("R10 second target 1", 32'(last_low), 32'h2);
      chk("R11 single select", 32'(multi), 32'h0);
      chk("R10 target length", 32'(tog), 32'd24);
      rd_reg(3'd2, s);
      chk("R10 first reply", s, 32'h7E);
      rd_reg(3'd3, s);
      chk("R7 overrun in per-word mode", s, 32'hD);
   endtask

   task automatic t_fixed_ignore();
      logic [31:0] s;
      wr_reg(3'd0, 32'h8);
      wr_reg(3'd1, (32'd3 << 16) | 32'h55);
      wait_idle();
      chk("R9 index field ignored", 32'(last_low), 32'h4);
      rd_reg(3'd2, s);
      chk("R9 reply", s, 32'hFFAA);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_basic();
      t_len();
      t_back();
      t_ovr();
      t_var();
      t_fixed_ignore();
      if (!finished) begin
         finished = 1;
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      #(8 * 150000);
      if (!finished) begin
         finished = 1;
         n_tests++; n_fail++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

endmodule